// File: doc/BRIEF.md
# Pipelined Binary32 Multiplier

This block multiplies two IEEE-754 single-precision operands and returns their product as a binary32 word. It accepts a new operand pair on any clock where the input strobe is high. The matching result comes out a fixed seven cycles later, so a steady stream gives one product per clock. There is no stall and no back-pressure. The output strobe is simply the input strobe delayed by the pipeline.

Special operands are classified before any arithmetic is done. An operand whose exponent field is zero counts as zero, even when its fraction is nonzero, so subnormal inputs are flushed. Zero, infinity and NaN operands force fixed results. Finite operands have their hidden one restored. The two 24-bit significands are multiplied by a carry-save array whose rows are spread over four pipeline stages, and one carry-propagate add turns the saved pair into the 48-bit product. The final stage normalises that product and truncates it to 23 fraction bits. It saturates to infinity when the exponent overflows and to zero when it underflows. No other rounding mode, subnormal result or exception flag is provided.

Top module: `fmul_top`

## Requirements
- R1: The sign bit of every zero, infinity or finite result is the XOR of the two operand sign bits.
- R2: An operand whose exponent field (bits 30:23) is 0 is treated as zero, whatever its fraction bits (bits 22:0) hold.
- R3: When either operand is zero, and neither is NaN or infinity, the result is a signed zero: exponent field 0 and fraction 0.
- R4: When one operand is infinity (exponent field 255, fraction 0) and the other is a nonzero non-NaN value, the result is a signed infinity: exponent field 255 and fraction 0.
- R5: When either operand is NaN (exponent field 255, fraction nonzero), or when zero is multiplied by infinity, the result is the quiet NaN 32'h7FC00000.
- R6: For finite nonzero operands whose significand product is below 2, the result exponent is ea + eb - 127, and the fraction is bits 45:23 of the 48-bit significand product.
- R7: When bit 47 of the significand product is set, the fraction is taken from bits 46:24 and the exponent is increased by one.
- R8: Product bits below the kept fraction are discarded; the fraction is truncated and never rounded up.
- R9: A final exponent above 254 produces a signed infinity.
- R10: A final exponent below 1 produces a signed zero; the output never has a zero exponent field with a nonzero fraction.
- R11: Each accepted operand pair produces exactly one result with out_valid high, seven clock edges after the edge that captures it (counting that edge as the first). Results leave in issue order at one per cycle.
- R12: While rst_n is low, and until the first captured input reaches the output, out_valid is low.
- R13: The 48-bit significand product formed by the array equals the exact product of the two 24-bit significands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 32 | First binary32 operand |
| in_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Product present this cycle |
| out_prod | output | 32 | Binary32 product |

## Verification
Hand-picked operand pairs separate the product paths. Products of exactly 1.0, products that reach 2.0 or more, and products with nonzero discarded bits distinguish plain exponent arithmetic, the normalising shift and truncation against rounding. Pairs placed at the exponent limits (254 and 1, just past each, and an underflow rescued by the normalising shift) locate the saturation thresholds exactly. Zero, subnormal, infinity and NaN operands, including subnormal times infinity, check that flushing happens before the special-case logic and in the right precedence. A long stream of random operands, sent back to back and with gaps, exercises the carry-save array across many bit patterns and confirms ordering and latency.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int WORD_W   = 1 + EXP_W + FRAC_W;
    localparam int EXPS_W   = EXP_W + 2;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_ONES = (1 << EXP_W) - 1;
    localparam int HEAD_W   = FRAC_W + 2;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // One slot of the multiply pipeline
    typedef struct packed {
        logic                     valid;
        logic                     sign;
        logic                     nan;
        logic                     inf;
        logic                     zero;
        logic signed [EXPS_W-1:0] exp;
        logic [SIG_W-1:0]         siga;
        logic [SIG_W-1:0]         sigb;
        logic [PROD_W-1:0]        acc_s;
        logic [PROD_W-1:0]        acc_c;
    } pipe_t;

endpackage

// File: rtl/fmul_prep.sv
module fmul_prep
    import fmul_pkg::*;
(
    input  logic              valid_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output pipe_t             stage_o
);

    logic [EXP_W-1:0]  ea, eb;
    logic [FRAC_W-1:0] fa, fb;
    logic              a_flush, b_flush;
    logic              a_top, b_top;
    logic              a_nan, b_nan;

    always_comb begin
        ea      = a_i[WORD_W-2 -: EXP_W];
        eb      = b_i[WORD_W-2 -: EXP_W];
        fa      = a_i[FRAC_W-1:0];
        fb      = b_i[FRAC_W-1:0];
        // exponent field zero covers both true zero and subnormal (flushed)
        a_flush = (ea == '0);
        b_flush = (eb == '0);
        a_top   = (ea == EXP_W'(EXP_ONES));
        b_top   = (eb == EXP_W'(EXP_ONES));
        a_nan   = a_top && (fa != '0);
        b_nan   = b_top && (fb != '0);

        stage_o.valid = valid_i;
        stage_o.sign  = a_i[WORD_W-1] ^ b_i[WORD_W-1];
        stage_o.nan   = a_nan || b_nan || (a_top && b_flush) || (b_top && a_flush);
        stage_o.inf   = a_top || b_top;
        stage_o.zero  = a_flush || b_flush;
        stage_o.exp   = {2'b00, ea} + {2'b00, eb} - EXPS_W'(BIAS);
        stage_o.siga  = {!a_flush, fa};
        stage_o.sigb  = {!b_flush, fb};
        stage_o.acc_s = '0;
        stage_o.acc_c = '0;
    end

endmodule

// File: rtl/fmul_csa_rows.sv
module fmul_csa_rows
    import fmul_pkg::*;
#(
    parameter int ROW_BASE = 0,
    parameter int ROWS     = 6
) (
    input  pipe_t stage_i,
    output pipe_t stage_o
);

    logic [PROD_W-1:0] sum_v, car_v, part_v, nsum_v, ncar_v;

    // Each row ANDs siga with one multiplier bit, then a row of full adders
    // folds it into the saved pair; carries move one column up per row.
    always_comb begin
        sum_v  = stage_i.acc_s;
        car_v  = stage_i.acc_c;
        part_v = '0;
        nsum_v = '0;
        ncar_v = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (ROW_BASE + r < SIG_W) begin
                part_v = (PROD_W'(stage_i.siga) & {PROD_W{stage_i.sigb[ROW_BASE + r]}})
                         << (ROW_BASE + r);
                nsum_v = sum_v ^ car_v ^ part_v;
                ncar_v = ((sum_v & car_v) | (sum_v & part_v) | (car_v & part_v)) << 1;
                sum_v  = nsum_v;
                car_v  = ncar_v;
            end
        end
        stage_o       = stage_i;
        stage_o.acc_s = sum_v;
        stage_o.acc_c = car_v;
    end

endmodule

// File: rtl/fmul_pack.sv
module fmul_pack
    import fmul_pkg::*;
(
    input  logic                     sign_i,
    input  logic                     nan_i,
    input  logic                     inf_i,
    input  logic                     zero_i,
    input  logic signed [EXPS_W-1:0] exp_i,
    input  logic [HEAD_W-1:0]        head_i,
    output logic [WORD_W-1:0]        word_o
);

    localparam logic signed [EXPS_W-1:0] E_MAX = EXPS_W'(EXP_ONES - 1);
    localparam logic signed [EXPS_W-1:0] E_MIN = EXPS_W'(1);

    logic                     hi;
    logic signed [EXPS_W-1:0] exp_adj;
    logic [FRAC_W-1:0]        frac;

    always_comb begin
        hi      = head_i[HEAD_W-1];
        exp_adj = exp_i + $signed({{(EXPS_W-1){1'b0}}, hi});
        frac    = hi ? head_i[HEAD_W-2:1] : head_i[FRAC_W-1:0];
        if (nan_i)
            word_o = QNAN_WORD;
        else if (inf_i || exp_adj > E_MAX)
            word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (zero_i || exp_adj < E_MIN)
            word_o = {sign_i, {(WORD_W-1){1'b0}}};
        else
            word_o = {sign_i, exp_adj[EXP_W-1:0], frac};
    end

endmodule

// File: rtl/fmul_top.sv
module fmul_top
    import fmul_pkg::*;
#(
    parameter int ROWS_PER_STAGE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_prod
);

    localparam int N_ARRAY = (SIG_W + ROWS_PER_STAGE - 1) / ROWS_PER_STAGE;
    localparam int NSTAGE  = N_ARRAY + 2;
    localparam int LAST    = NSTAGE - 1;
    localparam int LAT     = NSTAGE + 1;
    localparam int CNT_W   = $clog2(LAT + 2) + 1;

    typedef struct packed {
        pipe_t [NSTAGE-1:0] st;
        logic               ov;
        logic [WORD_W-1:0]  prod;
    } regs_t;

    regs_t             r_d, r_q;
    pipe_t             prep_o;
    pipe_t             csa_o [N_ARRAY];
    logic [WORD_W-1:0] pack_o;

    fmul_prep u_prep (
        .valid_i (in_valid),
        .a_i     (in_a),
        .b_i     (in_b),
        .stage_o (prep_o)
    );

    for (genvar k = 0; k < N_ARRAY; k++) begin : g_rows
        fmul_csa_rows #(
            .ROW_BASE (k * ROWS_PER_STAGE),
            .ROWS     (ROWS_PER_STAGE)
        ) u_rows (
            .stage_i (r_q.st[k]),
            .stage_o (csa_o[k])
        );
    end

    fmul_pack u_pack (
        .sign_i (r_q.st[LAST].sign),
        .nan_i  (r_q.st[LAST].nan),
        .inf_i  (r_q.st[LAST].inf),
        .zero_i (r_q.st[LAST].zero),
        .exp_i  (r_q.st[LAST].exp),
        .head_i (r_q.st[LAST].acc_s[PROD_W-1 -: HEAD_W]),
        .word_o (pack_o)
    );

    always_comb begin
        r_d       = r_q;
        r_d.st[0] = prep_o;
        for (int k = 0; k < N_ARRAY; k++) begin
            r_d.st[k+1] = csa_o[k];
        end
        r_d.st[LAST]       = r_q.st[LAST-1];
        r_d.st[LAST].acc_s = r_q.st[LAST-1].acc_s + r_q.st[LAST-1].acc_c;
        r_d.st[LAST].acc_c = '0;
        r_d.ov             = r_q.st[LAST].valid;
        r_d.prod           = pack_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.ov;
    assign out_prod  = r_q.prod;

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] inflight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    // R11: a result never appears without an accepted pair, and no more than LAT are open
    assert_no_orphan_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight_q != '0);
    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CNT_W'(LAT));

    // R13: resolved array output matches an exact multiply
    assert_exact_product_R13: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st[LAST].valid |->
            (r_q.st[LAST].acc_s + r_q.st[LAST].acc_c) ==
            (PROD_W'(r_q.st[LAST].siga) * PROD_W'(r_q.st[LAST].sigb)));

    // R5: any NaN leaving the block is the single quiet pattern
    assert_quiet_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prod[WORD_W-2 -: EXP_W] == EXP_W'(EXP_ONES)
                   && out_prod[FRAC_W-1:0] != '0) |-> out_prod == QNAN_WORD);

    // R10: no subnormal pattern is ever produced
    assert_no_subnormal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_prod[WORD_W-2 -: EXP_W] != '0) || (out_prod[FRAC_W-1:0] == '0));

    // R1: non-NaN output carries the sign formed at the front of the pipe
    assert_sign_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prod != QNAN_WORD) |-> out_prod[WORD_W-1] == $past(r_q.st[LAST].sign));

endmodule

// File: tb/tb_fmul_top.sv
`timescale 1ns/1ps
module tb_fmul_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_a, in_b;
    logic        out_valid;
    logic [31:0] out_prod;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    int          stamp_q[$];
    string       tag_q[$];

    logic [31:0] m_exp;
    int          m_stamp;
    string       m_tag;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fmul_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // model written from the requirement list
    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
        logic [7:0]  ea, eb;
        logic [22:0] fa, fb, f;
        logic        s, az, bz, ai, bi, an, bn;
        logic [47:0] p;
        int          e;
        ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
        s  = a[31] ^ b[31];
        az = (ea == 8'd0); bz = (eb == 8'd0);
        ai = (ea == 8'hFF) && (fa == 23'd0); bi = (eb == 8'hFF) && (fb == 23'd0);
        an = (ea == 8'hFF) && (fa != 23'd0); bn = (eb == 8'hFF) && (fb != 23'd0);
        if (an || bn || (ai && bz) || (bi && az)) return 32'h7FC00000;
        if (ai || bi) return {s, 8'hFF, 23'd0};
        if (az || bz) return {s, 31'd0};
        p = 48'({1'b1, fa}) * 48'({1'b1, fb});
        e = int'(ea) + int'(eb) - 127;
        if (p[47]) begin e = e + 1; f = p[46:24]; end
        else       f = p[45:23];
        if (e > 254) return {s, 8'hFF, 23'd0};
        if (e < 1)   return {s, 31'd0};
        return {s, e[7:0], f};
    endfunction

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] expv, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        exp_q.push_back(expv);
        stamp_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected result", out_prod, 32'h0);
            end else begin
                m_exp   = exp_q.pop_front();
                m_stamp = stamp_q.pop_front();
                m_tag   = tag_q.pop_front();
                check(out_prod === m_exp, m_tag, out_prod, m_exp);
                check((cyc - m_stamp) == 7, "R11 latency", 32'(cyc - m_stamp), 32'd7);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] ra, rb;
        in_valid = 1'b0; in_a = '0; in_b = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R12 in reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R12 after reset", {31'd0, out_valid}, 32'd0);

        // directed, back to back
        send(32'h3F800000, 32'h3F800000, 32'h3F800000, "R6 one times one");
        send(32'h3FC00000, 32'h3FC00000, 32'h40100000, "R7 1.5 squared");
        send(32'hC0000000, 32'h40400000, 32'hC0C00000, "R1 minus two times three");
        send(32'h3F800001, 32'h3F800001, 32'h3F800002, "R8 truncation");
        send(32'h80000000, 32'h40400000, 32'h80000000, "R3 signed zero");
        send(32'h00000001, 32'h40000000, 32'h00000000, "R2 subnormal flush");
        send(32'h80000001, 32'h40000000, 32'h80000000, "R2 negative subnormal");
        send(32'h7F800000, 32'hC0000000, 32'hFF800000, "R4 inf times minus two");
        send(32'h00000000, 32'h7F800000, 32'h7FC00000, "R5 zero times inf");
        send(32'h00000001, 32'h7F800000, 32'h7FC00000, "R5 subnormal times inf");
        send(32'h7F800001, 32'h3F800000, 32'h7FC00000, "R5 NaN input");
        send(32'h7F000000, 32'h3F800000, 32'h7F000000, "R9 exponent 254 kept");
        send(32'h7F000000, 32'h40800000, 32'h7F800000, "R9 overflow");
        send(32'h7F400000, 32'h3FC00000, 32'h7F800000, "R9 overflow by shift");
        send(32'h00800000, 32'h3F800000, 32'h00800000, "R10 exponent 1 kept");
        send(32'h00800000, 32'h3F000000, 32'h00000000, "R10 underflow");
        send(32'h80800000, 32'h3F000000, 32'h80000000, "R10 negative underflow");
        send(32'h00C00000, 32'h3F400000, 32'h00900000, "R7 shift rescues underflow");
        idle(10);

        // random stream with occasional gaps
        for (int i = 0; i < 400; i++) begin
            ra = {1'($urandom), 8'($urandom_range(1, 254)), 23'($urandom)};
            rb = {1'($urandom), 8'($urandom_range(1, 254)), 23'($urandom)};
            send(ra, rb, model(ra, rb), "R13 random");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(12);
        check(exp_q.size() == 0, "R11 all delivered", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule